// File: doc/BRIEF.md
# Periodic and Alarm Interrupt Controller

This block merges eight time-keeping event sources into one active-high interrupt line. Each source arrives as a single-cycle strobe: seven come from the calendar counter chain and one from the alarm comparator. The seven counter strobes pulse when the tenths-of-second, second, minute, hour, day, week or month counter wraps to zero. The eighth pulses when the alarm compare matches. A control register, written over a simple register bus, enables each source on its own. A status register records which enabled events have occurred since it was last read.

Software reads the status register to learn which events caused the interrupt. That read also clears every latched bit at once, so there is no per-bit write-one-to-clear. An event that lands in the same cycle as the clearing read is not lost. It shows up in the next read.

Top module: `tick_irq_ctrl`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0 and `irq_o` is low.
- R2: A write with `sel_i`=0 loads `wdata_i` into the control register. A read with `sel_i`=0 returns that value.
- R3: Bit k of `evt_i` maps to status bit k. The map is: 0 tenth-second, 1 second, 2 minute, 3 hour, 4 day, 5 week, 6 month, 7 alarm. A strobe on a source whose control bit is 1 sets its status bit on that clock edge.
- R4: A strobe on a source whose control bit is 0 never sets its status bit.
- R5: `irq_o` is high exactly while at least one status bit is set. It rises the cycle after an enabled strobe.
- R6: A read with `sel_i`=1 returns the latched status bits and clears all of them on that clock edge.
- R7: An enabled strobe in the same cycle as a status read is latched and appears in the following read.
- R8: Reading the control register leaves the status register unchanged.
- R9: A write with `sel_i`=1 has no effect on the status or control register.
- R10: The enable mask used for a strobe is the one held before that cycle. A strobe coinciding with the write that enables it is not latched.
- R11: Status bits are sticky. Events on different cycles accumulate until a status read.
- R12: `rdata_o` is 0 in any cycle where `rd_i` is low.

Ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NSRC | Source strobes, one cycle each |
| sel_i | input | 1 | Register select: 0 control, 1 status |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | NSRC | Write data |
| rdata_o | output | NSRC | Read data |
| irq_o | output | 1 | Active-high interrupt |

## Verification
A table walks enable masks against strobe patterns. These include full enable, no enable, disjoint masks, overlapping masks and single-bit masks at either end. Together they separate a design that ignores the mask, inverts it or shifts the bit mapping from a correct one. Directed cases then aim at the timing corners. They cover a strobe colliding with the clearing read, a strobe colliding with the enabling write, and accumulation across cycles. They also cover bus accesses that must leave state alone: control reads and writes aimed at the status register.

// File: rtl/tick_irq_ctrl.sv
`timescale 1ns/1ps
module tick_irq_ctrl #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic            sel_i,
  input  logic            wr_i,
  input  logic            rd_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] rdata_o,
  output logic            irq_o
);

  logic [NSRC-1:0] ctl_q;
  logic [NSRC-1:0] stat_q;

  wire ctl_wr  = wr_i & ~sel_i;
  wire stat_rd = rd_i & sel_i;

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_wr) ctl_q <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_rd ? '0 : stat_q) | (evt_i & ctl_q);
  end

  assign rdata_o = rd_i ? (sel_i ? stat_q : ctl_q) : '0;
  assign irq_o   = |stat_q;

endmodule

// File: rtl/tick_irq_ctrl_chk.sv
`timescale 1ns/1ps
module tick_irq_ctrl_chk #(
  parameter int NSRC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] evt_i,
  input logic            sel_i,
  input logic            rd_i,
  input logic [NSRC-1:0] ctl_q,
  input logic [NSRC-1:0] stat_q,
  input logic            irq_o,
  input logic [NSRC-1:0] rdata_o
);

  AST_ENABLED_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i & ctl_q) != '0) |=> irq_o); // R3

  AST_MASKED_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(ctl_q) & ~$past(stat_q)) == '0)); // R4

  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(evt_i & ctl_q) != '0)); // R5

  AST_READ_CLEARS_KEEPS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && sel_i) |=> (stat_q == $past(evt_i & ctl_q))); // R6 R7

  AST_STICKY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_i && sel_i) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R11

  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |-> (rdata_o == '0)); // R12

endmodule

bind tick_irq_ctrl tick_irq_ctrl_chk #(.NSRC(NSRC)) chk_i (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .sel_i(sel_i), .rd_i(rd_i),
  .ctl_q(ctl_q), .stat_q(stat_q), .irq_o(irq_o), .rdata_o(rdata_o)
);

// File: tb/tick_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module tick_irq_ctrl_tb_top;
  localparam int N = 8;
  localparam int NV = 8;
  // each entry: {enable mask, strobe pattern, expected status}
  localparam logic [23:0] VEC [NV] = '{
    {8'hFF, 8'h01, 8'h01}, {8'hFF, 8'h80, 8'h80},
    {8'h0F, 8'hFF, 8'h0F}, {8'h00, 8'hFF, 8'h00},
    {8'hAA, 8'h55, 8'h00}, {8'hAA, 8'hFF, 8'hAA},
    {8'h81, 8'h81, 8'h81}, {8'h7E, 8'hC3, 8'h42}
  };

  logic clk = 0, rst_n = 0, sel = 0, wr = 0, rd = 0;
  logic [N-1:0] evt = '0, wdata = '0;
  logic [N-1:0] rdata;
  logic irq;
  int checks = 0, errors = 0, cycles = 0;

  always #4 clk = ~clk;

  tick_irq_ctrl #(.NSRC(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .sel_i(sel), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired act=%0d exp=<20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic s, input logic [N-1:0] d, input logic [N-1:0] e);
    sel = s; wr = 1; wdata = d; evt = e;
    @(negedge clk);
    wr = 0; evt = '0;
  endtask

  task automatic pulse(input logic [N-1:0] e);
    evt = e;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic rd_reg(input logic s, input logic [N-1:0] e, output logic [N-1:0] v);
    sel = s; rd = 1; evt = e;
    #1 v = rdata;
    @(negedge clk);
    rd = 0; evt = '0;
  endtask

  logic [N-1:0] v;

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status", dut_i.rdata_o, '0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq", {7'b0, irq}, '0);
    rd_reg(0, '0, v); chk("R1 control", v, '0);
    rd_reg(1, '0, v); chk("R1 status read", v, '0);
    chk("R12 idle bus", rdata, '0);

    for (int i = 0; i < NV; i++) begin
      wr_reg(0, VEC[i][23:16], '0);
      rd_reg(0, '0, v); chk("R2 control readback", v, VEC[i][23:16]);
      pulse(VEC[i][15:8]);
      chk("R5 irq level", {7'b0, irq}, {7'b0, VEC[i][7:0] != '0});
      rd_reg(1, '0, v); chk("R3 R4 status", v, VEC[i][7:0]);
      chk("R6 cleared irq", {7'b0, irq}, '0);
    end

    // R7: strobe together with clearing read
    wr_reg(0, 8'hFF, '0);
    pulse(8'h04);
    rd_reg(1, 8'h10, v); chk("R7 first read", v, 8'h04);
    chk("R7 irq kept", {7'b0, irq}, 8'h01);
    rd_reg(1, '0, v); chk("R7 second read", v, 8'h10);

    // R8: control read leaves status
    pulse(8'h20);
    rd_reg(0, '0, v); chk("R8 control value", v, 8'hFF);
    rd_reg(1, '0, v); chk("R8 status kept", v, 8'h20);

    // R9: write to status address ignored
    pulse(8'h02);
    wr_reg(1, 8'h00, '0);
    wr_reg(1, 8'hFF, '0);
    rd_reg(0, '0, v); chk("R9 control intact", v, 8'hFF);
    rd_reg(1, '0, v); chk("R9 status intact", v, 8'h02);

    // R10: strobe coinciding with enabling write
    wr_reg(0, 8'h00, '0);
    wr_reg(0, 8'h08, 8'h08);
    chk("R10 irq", {7'b0, irq}, '0);
    rd_reg(1, '0, v); chk("R10 not latched", v, '0);
    pulse(8'h08);
    rd_reg(1, '0, v); chk("R10 next latched", v, 8'h08);

    // R11: accumulation
    wr_reg(0, 8'hFF, '0);
    pulse(8'h01);
    pulse('0);
    pulse(8'h40);
    pulse(8'h01);
    rd_reg(1, '0, v); chk("R11 accumulated", v, 8'h41);
    rd_reg(1, '0, v); chk("R6 empty after read", v, '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule